// File: doc/BRIEF.md
# Washer-Dryer Cycle Sequencer

This block sequences a two-phase appliance programme. The wash phase comes first and the dry phase second. Each phase keeps its own up-counter. The wash counter climbs from zero to its terminal value and parks there. Only then does the dry counter start to climb, from zero to its own terminal value, where it also parks. Once the dry counter has parked, the programme is complete.

Both counters move only on clock cycles where the `start` level and a pacing strobe `tick` are both high. Dropping `start` pauses the whole programme in place. The strobe lets the surrounding logic set the rate, for example one step per second. A synchronous active-low reset returns the block to the beginning of the wash phase, and it overrides every other input.

The outputs are the two counts, a flag for each active phase and a completion flag. The terminal counts are parameters and default to 6 for washing and 4 for drying.

Top module: `wd_sequencer`

## Requirements
- R1: When `start` and `tick` are both high at a clock edge and the wash count is below WASH_LAST (default 6), the wash count rises by exactly one. Once it reaches WASH_LAST it never changes until reset.
- R2: The dry count stays 0 while the wash count is below WASH_LAST. It rises by one at each edge where `start` and `tick` are high and the wash count already equalled WASH_LAST before that edge. It stops at DRY_LAST (default 4). The edge that brings washing to WASH_LAST does not advance the dry count.
- R3: At an edge where `start` is low, both counts keep their values, whatever `tick` is.
- R4: At an edge where `tick` is low, both counts keep their values, whatever `start` is.
- R5: At a clock edge where `rst_n` is low, both counts become 0, `done` becomes 0 and the programme returns to the wash phase. This happens even when `start` and `tick` are high.
- R6: `washing` is high exactly when `start` is high and the wash count is below WASH_LAST.
- R7: `drying` is high exactly when `start` is high, the wash count equals WASH_LAST and the dry count is below DRY_LAST.
- R8: `done` is high exactly when the dry count equals DRY_LAST. It does not depend on `start`, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Run level; low pauses both phases |
| tick | input | 1 | Pacing strobe; a count step needs this high |
| wash_cnt | output | $clog2(WASH_LAST+1) | Wash phase count |
| dry_cnt | output | $clog2(DRY_LAST+1) | Dry phase count |
| washing | output | 1 | Wash phase active and running |
| drying | output | 1 | Dry phase active and running |
| done | output | 1 | Programme complete |

## Verification
The bench runs full programmes under several input patterns, and a model checks the counts and flags after every cycle:
- **Both inputs held high.** Gives the minimal-length programme, which exposes an off-by-one at either terminal value and any overlap at the handover between phases.
- **Sparse `tick`.** Shows whether the strobe is really required.
- **`start` toggling.** Shows that pauses freeze the counts while the flags drop with `start`.
- **Pseudo-random mixes of both inputs.** Reach stall points that the regular patterns miss.

Three targeted checks follow:
- A cycle with `start` low and `tick` high, and a cycle with `tick` low and `start` high. These separate the two enable conditions.
- A reset taken with both inputs high, in the middle of a programme and after completion. This shows that reset wins over `start`.

// File: rtl/wd_pkg.sv
// Package wd_pkg
// Shared types for the washer-dryer sequencer.
// The phase code is one-hot, so each phase is decoded from a single bit.
package wd_pkg;

    typedef enum logic [2:0] {
        PH_WASH = 3'b001,
        PH_DRY  = 3'b010,
        PH_DONE = 3'b100
    } wd_phase_e;

endpackage

// File: rtl/wd_step_counter.sv
// Module wd_step_counter
// Saturating up-counter with an enable. It starts at zero, steps by one on
// each enabled edge and parks at LAST.
// It reports when it is parked (at_end) and when the next step will park it
// (near_end).
// Assumes LAST >= 1 and that W is wide enough to hold LAST.
module wd_step_counter #(
    parameter int LAST = 6,
    parameter int W    = $clog2(LAST + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         at_end,
    output logic         near_end
);

    localparam logic [W-1:0] CNT_END  = W'(LAST);
    localparam logic [W-1:0] CNT_PREV = W'(LAST - 1);
    localparam logic [W-1:0] CNT_ONE  = W'(1);

    logic [W-1:0] cnt_q;

    // Count register: clears on reset, steps while enabled and not parked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != CNT_END)) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // Terminal decodes for the phase controller.
    always_comb begin
        at_end   = (cnt_q == CNT_END);
        near_end = (cnt_q == CNT_PREV);
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/wd_phase_ctrl.sv
// Module wd_phase_ctrl
// One-hot phase machine for the programme: wash, then dry, then done.
// It leaves a phase on the same edge that parks that phase's counter, so the
// phase code always matches the counter values.
// It gates each counter's enable with start, tick and the current phase.
// Assumes near_end/at_end come from counters that this block enables.
module wd_phase_ctrl
    import wd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      tick,
    input  logic      wash_near_end,
    input  logic      dry_near_end,
    output logic      wash_en,
    output logic      dry_en,
    output logic      washing,
    output logic      drying,
    output logic      done,
    output wd_phase_e phase
);

    wd_phase_e phase_q;
    wd_phase_e phase_d;
    logic      step_ok;

    // Qualified step: the programme runs and the pacing strobe is present.
    always_comb begin
        step_ok = start && tick;
        wash_en = step_ok && (phase_q == PH_WASH);
        dry_en  = step_ok && (phase_q == PH_DRY);
    end

    // Next phase: move on when the last step of the current phase is taken.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_WASH: if (wash_en && wash_near_end) phase_d = PH_DRY;
            PH_DRY:  if (dry_en && dry_near_end)   phase_d = PH_DONE;
            PH_DONE: phase_d = PH_DONE;
            default: phase_d = PH_WASH;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_WASH;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Status flags decoded from single one-hot bits.
    always_comb begin
        washing = start && phase_q[0];
        drying  = start && phase_q[1];
        done    = phase_q[2];
    end

    assign phase = phase_q;

endmodule

// File: rtl/wd_sequencer.sv
// Module wd_sequencer
// Top of the washer-dryer sequencer. It chains a wash counter and a dry
// counter under a one-hot phase controller.
// Both counters advance only on edges where start and tick are high.
// Assumes WASH_LAST >= 1, DRY_LAST >= 1 and tick synchronous to clk.
module wd_sequencer
    import wd_pkg::*;
#(
    parameter int WASH_LAST = 6,
    parameter int DRY_LAST  = 4,
    localparam int WW = $clog2(WASH_LAST + 1),
    localparam int DW = $clog2(DRY_LAST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tick,
    output logic [WW-1:0] wash_cnt,
    output logic [DW-1:0] dry_cnt,
    output logic          washing,
    output logic          drying,
    output logic          done
);

    logic      wash_en;
    logic      dry_en;
    logic      wash_at_end;
    logic      wash_near_end;
    logic      dry_at_end;
    logic      dry_near_end;
    wd_phase_e phase;

    wd_phase_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .tick          (tick),
        .wash_near_end (wash_near_end),
        .dry_near_end  (dry_near_end),
        .wash_en       (wash_en),
        .dry_en        (dry_en),
        .washing       (washing),
        .drying        (drying),
        .done          (done),
        .phase         (phase)
    );

    wd_step_counter #(.LAST(WASH_LAST), .W(WW)) u_wash (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (wash_en),
        .cnt      (wash_cnt),
        .at_end   (wash_at_end),
        .near_end (wash_near_end)
    );

    wd_step_counter #(.LAST(DRY_LAST), .W(DW)) u_dry (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (dry_en),
        .cnt      (dry_cnt),
        .at_end   (dry_at_end),
        .near_end (dry_near_end)
    );

    // Consistency between the phase code and the counter decodes.
    always_comb begin
        if (rst_n && (phase == PH_DONE)) begin
            assert (wash_at_end && dry_at_end)
                else $error("p_done_phase_r8: done phase with counters not parked");
        end
    end

endmodule

// File: rtl/wd_sequencer_chk.sv
// Module wd_sequencer_chk
// Checker for wd_sequencer. It watches only the top-level ports and is
// attached with the bind statement at the end of this file.
module wd_sequencer_chk #(
    parameter int WASH_LAST = 6,
    parameter int DRY_LAST  = 4,
    localparam int WW = $clog2(WASH_LAST + 1),
    localparam int DW = $clog2(DRY_LAST + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          tick,
    input logic [WW-1:0] wash_cnt,
    input logic [DW-1:0] dry_cnt,
    input logic          washing,
    input logic          drying,
    input logic          done
);

    localparam logic [WW-1:0] W_END = WW'(WASH_LAST);
    localparam logic [DW-1:0] D_END = DW'(DRY_LAST);
    localparam logic [WW-1:0] W_ONE = WW'(1);
    localparam logic [DW-1:0] D_ONE = DW'(1);

    p_wash_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && tick && wash_cnt != W_END) |=> (wash_cnt == $past(wash_cnt) + W_ONE));

    p_wash_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wash_cnt == W_END) |=> (wash_cnt == W_END));

    p_dry_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wash_cnt != W_END) |=> (dry_cnt == '0));

    p_dry_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && tick && wash_cnt == W_END && dry_cnt != D_END)
        |=> (dry_cnt == $past(dry_cnt) + D_ONE));

    p_hold_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start) |=> ($stable(wash_cnt) && $stable(dry_cnt)));

    p_hold_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick) |=> ($stable(wash_cnt) && $stable(dry_cnt)));

    p_reset_r5: assert property (@(posedge clk)
        (!rst_n) |=> (wash_cnt == '0 && dry_cnt == '0 && !done));

    p_one_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({washing, drying, done}));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

bind wd_sequencer wd_sequencer_chk #(
    .WASH_LAST (WASH_LAST),
    .DRY_LAST  (DRY_LAST)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tick     (tick),
    .wash_cnt (wash_cnt),
    .dry_cnt  (dry_cnt),
    .washing  (washing),
    .drying   (drying),
    .done     (done)
);

// File: tb/wd_sequencer_test.sv
// Bench for wd_sequencer. It sweeps start/tick patterns against an arithmetic
// model of the two-phase programme.
module wd_sequencer_test;

    localparam int WL = 6;
    localparam int DL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] wash_cnt;
    logic [2:0] dry_cnt;
    logic       washing;
    logic       drying;
    logic       done;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_w   = 0;
    int exp_d   = 0;

    wd_sequencer #(.WASH_LAST(WL), .DRY_LAST(DL)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .wash_cnt (wash_cnt),
        .dry_cnt  (dry_cnt),
        .washing  (washing),
        .drying   (drying),
        .done     (done)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare every output with the model.
    task automatic chk_all();
        chk("R1 wash count", int'(wash_cnt), exp_w);
        chk("R2 dry count", int'(dry_cnt), exp_d);
        chk("R6 washing", int'(washing), int'(start && exp_w < WL));
        chk("R7 drying", int'(drying), int'(start && exp_w == WL && exp_d < DL));
        chk("R8 done", int'(done), int'(exp_d == DL));
    endtask

    // One cycle: drive at negedge, update the model at the edge, check at the
    // following negedge.
    task automatic cyc(input logic s, input logic t, input logic r);
        start = s;
        tick  = t;
        rst_n = r;
        @(posedge clk);
        if (!r) begin
            exp_w = 0;
            exp_d = 0;
        end else if (s && t) begin
            if (exp_w < WL)      exp_w++;
            else if (exp_d < DL) exp_d++;
        end
        @(negedge clk);
        chk_all();
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        @(negedge clk);
        cyc(1'b1, 1'b1, 1'b0);
        chk("R5 reset state wash", int'(wash_cnt), 0);

        // Pattern sweep: 0 all high, 1 sparse tick, 2 toggling start,
        // 3..6 pseudo-random mixes.
        for (int p = 0; p < 7; p++) begin
            lfsr = 8'hA5 ^ 8'(p * 37);
            cyc(1'b1, 1'b1, 1'b0);
            for (int c = 0; c < 40; c++) begin
                logic s;
                logic t;
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                case (p)
                    0:       begin s = 1'b1;         t = 1'b1;          end
                    1:       begin s = 1'b1;         t = (c % 3 == 0);  end
                    2:       begin s = (c % 4 < 2);  t = 1'b1;          end
                    default: begin s = lfsr[0];      t = lfsr[3];       end
                endcase
                cyc(s, t, 1'b1);
            end
        end

        // R1/R2 handover: the edge that parks washing must not move drying.
        cyc(1'b1, 1'b1, 1'b0);
        for (int c = 0; c < WL; c++) cyc(1'b1, 1'b1, 1'b1);
        chk("R2 handover dry still 0", int'(dry_cnt), 0);
        chk("R1 wash parked", int'(wash_cnt), WL);

        // R3: start low with tick high holds both counts.
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b1);
        chk("R3 hold dry", int'(dry_cnt), 1);
        chk("R3 hold wash", int'(wash_cnt), WL);

        // R4: tick low with start high holds both counts.
        cyc(1'b1, 1'b0, 1'b1);
        chk("R4 hold dry", int'(dry_cnt), 1);

        // R5: mid-programme reset with start and tick high.
        cyc(1'b1, 1'b1, 1'b0);
        chk("R5 mid reset dry", int'(dry_cnt), 0);
        chk("R5 mid reset wash", int'(wash_cnt), 0);

        // R8: run to completion, then done stays through start low.
        for (int c = 0; c < WL + DL + 3; c++) cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R8 done sticky", int'(done), 1);
        cyc(1'b1, 1'b1, 1'b0);
        chk("R8 done cleared by reset", int'(done), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule